// File: doc/BRIEF.md
# Upper Address Pin Chip-Select Decoder

This block drives the four most significant address pins of a 32-bit processor's external bus. A strap input, sampled while reset is held, picks one of two modes. In address mode the pins carry address bits 31 to 28. In select mode they carry four active-low chip selects. Each select is raised by one of two fixed address windows, a cachable one and an uncachable one.

In select mode the block compares the bus address with eight hard-wired windows. It drives the matching select low only during memory cycles that are in progress. I/O cycles, unmatched addresses and idle bus time leave all four pins high. The pins are registered and change only on rising clock edges in particular bus states. Which states those are depends on whether the bus runs 32 or 16 bits wide. The bus sequencer, the data path and wait-state generation sit outside this block and supply its inputs.

Top module: `upper_pin_csdec`

## Requirements
- R1: The mode strap is captured on every clock edge while rst_n is low, so the value at the last reset edge is kept. It stays constant until the next reset: a strap change after reset has no effect on the pins. Strap 1 selects address mode, strap 0 selects select mode.
- R2: In address mode, upper_pins_o[3:0] takes addr_i[31:28] on each update edge. Outside update edges it holds, and it also holds while no bus cycle is active.
- R3: In select mode, upper_pins_o[k] is the active-low select k. Select 0 covers 7E000000h-7FFFFFFFh and FE001000h-FFFFFFFFh. Select 1 covers 40000000h-4FFFFFFFh and 00001000h-0FFFFFFFh. Select 2 covers 50000000h-5FFFFFFFh and 10000000h-1FFFFFFFh. Select 3 covers 60000000h-6FFFFFFFh and 20000000h-2FFFFFFFh. All bounds are inclusive.
- R4: In select mode, an address outside every window drives all four pins high on an update edge. Examples are 00000000h-00000FFFh, 30000000h and 80000000h.
- R5: In select mode, a cycle with mem_cycle_i = 0 (I/O) drives all four pins high on an update edge, whatever the address.
- R6: In select mode, every clock edge with cyc_active_i = 0 drives all four pins high.
- R7: bus_state_i encodes 0 idle, 1 address state, 2 setup, 3 first wait, 4 second wait, and 5 to 12 data beats 1 to 8. With bus16_i = 0, the update edges are edges with cyc_active_i = 1 and state 1, 6, 7 or 8. All other edges hold the pins.
- R8: With bus16_i = 1, the update edges are edges with cyc_active_i = 1 and state 1, 4, or 6 to 12. States 2, 3 and 5 hold the pins.
- R9: In select mode, at most one pin is low at any time.
- R10: The edge after any reset edge leaves all four pins high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr_mode_i | input | 1 | Mode strap: 1 address bits, 0 chip selects |
| addr_i | input | 32 | Current bus address |
| cyc_active_i | input | 1 | Bus cycle in progress |
| mem_cycle_i | input | 1 | 1 memory cycle, 0 I/O cycle |
| bus16_i | input | 1 | 1 when the bus runs 16 bits wide |
| bus_state_i | input | 4 | Current bus state code (see R7) |
| upper_pins_o | output | 4 | Address bits 31:28 or active-low selects 3:0 |

## Verification
The block holds only two pieces of state: the latched mode and the pin register. Both show at the ports one clock after the edge that writes them. A wrong mode latch corrupts the very next update, because the pins then show address bits instead of selects or the other way round. A pin register that loads on the wrong edge shows up in two ways. It changes during a setup, wait or first-beat state, or it keeps a stale select across the state that should have refreshed it. The bench exposes both by changing the address between states of one cycle. Decode faults show at the first and last address of a window and at the address just outside it, which the boundary sweep visits for all eight windows.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

    localparam int ADDR_W  = 32;
    localparam int NUM_SEL = 4;
    localparam int NUM_WIN = 2;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_ADDR  = 4'd1,
        ST_SETUP = 4'd2,
        ST_WAIT1 = 4'd3,
        ST_WAIT2 = 4'd4,
        ST_DAT1  = 4'd5,
        ST_DAT2  = 4'd6,
        ST_DAT3  = 4'd7,
        ST_DAT4  = 4'd8,
        ST_DAT5  = 4'd9,
        ST_DAT6  = 4'd10,
        ST_DAT7  = 4'd11,
        ST_DAT8  = 4'd12
    } bus_state_e;

    typedef struct packed {
        logic               addr_mode;
        logic [NUM_SEL-1:0] pins;
    } pin_reg_t;

    // window 0 = uncachable alias, window 1 = cachable alias
    function automatic logic [ADDR_W-1:0] win_base(input int sel, input int win);
        logic [ADDR_W-1:0] b;
        case (sel * NUM_WIN + win)
            0:       b = 32'h7E00_0000;
            1:       b = 32'hFE00_1000;
            2:       b = 32'h4000_0000;
            3:       b = 32'h0000_1000;
            4:       b = 32'h5000_0000;
            5:       b = 32'h1000_0000;
            6:       b = 32'h6000_0000;
            default: b = 32'h2000_0000;
        endcase
        return b;
    endfunction

    function automatic logic [ADDR_W-1:0] win_last(input int sel, input int win);
        logic [ADDR_W-1:0] l;
        case (sel * NUM_WIN + win)
            0:       l = 32'h7FFF_FFFF;
            1:       l = 32'hFFFF_FFFF;
            2:       l = 32'h4FFF_FFFF;
            3:       l = 32'h0FFF_FFFF;
            4:       l = 32'h5FFF_FFFF;
            5:       l = 32'h1FFF_FFFF;
            6:       l = 32'h6FFF_FFFF;
            default: l = 32'h2FFF_FFFF;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/csdec_range_cmp.sv
module csdec_range_cmp #(
    parameter int                AW   = 32,
    parameter logic [AW-1:0]     BASE = '0,
    parameter logic [AW-1:0]     LAST = '1
) (
    input  logic [AW-1:0] addr_i,
    output logic          hit_o
);
    localparam logic [AW-1:0] SPAN = LAST - BASE;

    logic [AW-1:0] offs;

    // one subtract and one compare: below-base addresses wrap to large offsets
    assign offs  = addr_i - BASE;
    assign hit_o = (offs <= SPAN);
endmodule

// File: rtl/csdec_select_decode.sv
module csdec_select_decode
    import csdec_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int NSEL = NUM_SEL,
    parameter int NWIN = NUM_WIN
) (
    input  logic [AW-1:0]   addr_i,
    input  logic            mem_i,
    output logic [NSEL-1:0] sel_hit_o
);
    localparam int NRAW = NSEL * NWIN;

    logic [NRAW-1:0] raw_hit;

    for (genvar s = 0; s < NSEL; s++) begin : g_sel
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            csdec_range_cmp #(
                .AW   (AW),
                .BASE (AW'(win_base(s, w))),
                .LAST (AW'(win_last(s, w)))
            ) u_cmp (
                .addr_i (addr_i),
                .hit_o  (raw_hit[s*NWIN + w])
            );
        end
        assign sel_hit_o[s] = mem_i & (|raw_hit[s*NWIN +: NWIN]);
    end
endmodule

// File: rtl/csdec_update_gate.sv
module csdec_update_gate
    import csdec_pkg::*;
(
    input  logic       bus16_i,
    input  logic [3:0] state_i,
    output logic       upd_o
);
    bus_state_e st;

    assign st = bus_state_e'(state_i);

    always_comb begin
        upd_o = 1'b0;
        case (st)
            ST_ADDR:                    upd_o = 1'b1;
            ST_DAT2, ST_DAT3, ST_DAT4:  upd_o = 1'b1;
            ST_WAIT2:                   upd_o = bus16_i;
            ST_DAT5, ST_DAT6,
            ST_DAT7, ST_DAT8:           upd_o = bus16_i;
            default:                    upd_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/upper_pin_csdec.sv
module upper_pin_csdec
    import csdec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_addr_mode_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                cyc_active_i,
    input  logic                mem_cycle_i,
    input  logic                bus16_i,
    input  logic [3:0]          bus_state_i,
    output logic [NUM_SEL-1:0]  upper_pins_o
);
    localparam int TOP_LSB = ADDR_W - NUM_SEL;

    pin_reg_t             reg_d, reg_q;
    logic [NUM_SEL-1:0]   sel_hit;
    logic                 state_upd;
    logic                 upd_en;
    logic                 addr_mode_w;

    csdec_select_decode #(
        .AW   (ADDR_W),
        .NSEL (NUM_SEL),
        .NWIN (NUM_WIN)
    ) u_decode (
        .addr_i    (addr_i),
        .mem_i     (mem_cycle_i),
        .sel_hit_o (sel_hit)
    );

    csdec_update_gate u_gate (
        .bus16_i (bus16_i),
        .state_i (bus_state_i),
        .upd_o   (state_upd)
    );

    assign upd_en = cyc_active_i & state_upd;

    always_comb begin
        reg_d = reg_q;
        if (reg_q.addr_mode) begin
            if (upd_en) begin
                reg_d.pins = addr_i[ADDR_W-1:TOP_LSB];
            end
        end else begin
            if (!cyc_active_i) begin
                reg_d.pins = '1;
            end else if (upd_en) begin
                reg_d.pins = ~sel_hit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q.addr_mode <= strap_addr_mode_i;
            reg_q.pins      <= '1;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign addr_mode_w  = reg_q.addr_mode;
    assign upper_pins_o = reg_q.pins;
endmodule

// File: rtl/csdec_checker.sv
module csdec_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       addr_mode,
    input logic       cyc,
    input logic       mem,
    input logic [3:0] state,
    input logic [3:0] addr_top,
    input logic [3:0] pins
);
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(addr_mode)); // R1

    AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_mode && cyc && state == 4'd1) |=> pins == $past(addr_top)); // R2

    AST_IO_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_mode && cyc && !mem && state == 4'd1) |=> pins == 4'hF); // R5

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_mode && !cyc) |=> pins == 4'hF); // R6

    AST_HOLD_NONUPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && (state == 4'd2 || state == 4'd3 || state == 4'd5)) |=> $stable(pins)); // R7

    AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mode |-> $countones(~pins) <= 1); // R9

    AST_RESET_VALUE: assert property (@(posedge clk)
        !rst_n |=> pins == 4'hF); // R10
endmodule

bind upper_pin_csdec csdec_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_mode (addr_mode_w),
    .cyc       (cyc_active_i),
    .mem       (mem_cycle_i),
    .state     (bus_state_i),
    .addr_top  (addr_i[31:28]),
    .pins      (upper_pins_o)
);

// File: tb/tb_upper_pin_csdec.sv
module tb_upper_pin_csdec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic [31:0] addr = '0;
    logic        cyc = 1'b0;
    logic        mem = 1'b1;
    logic        b16 = 1'b0;
    logic [3:0]  st = 4'd0;
    logic [3:0]  pins;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    upper_pin_csdec dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .strap_addr_mode_i (strap),
        .addr_i            (addr),
        .cyc_active_i      (cyc),
        .mem_cycle_i       (mem),
        .bus16_i           (b16),
        .bus_state_i       (st),
        .upper_pins_o      (pins)
    );

    // window table: first address, last address, select index
    localparam logic [31:0] W_LO [8] = '{32'hFE00_1000, 32'h7E00_0000, 32'h0000_1000, 32'h4000_0000,
                                         32'h1000_0000, 32'h5000_0000, 32'h2000_0000, 32'h6000_0000};
    localparam logic [31:0] W_HI [8] = '{32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h0FFF_FFFF, 32'h4FFF_FFFF,
                                         32'h1FFF_FFFF, 32'h5FFF_FFFF, 32'h2FFF_FFFF, 32'h6FFF_FFFF};
    localparam int          W_CS [8] = '{0, 0, 1, 1, 2, 2, 3, 3};

    function automatic logic [3:0] model_sel(input logic [31:0] a, input logic m);
        logic [3:0] r = 4'hF;
        if (m) begin
            for (int i = 0; i < 8; i++) begin
                if (a >= W_LO[i] && a <= W_HI[i]) r[W_CS[i]] = 1'b0;
            end
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // drive at negedge, one rising edge, sample at next negedge
    task automatic step(input logic c, input logic [3:0] s, input logic [31:0] a);
        cyc  = c;
        st   = s;
        addr = a;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic s);
        rst_n = 1'b0;
        strap = s;
        cyc   = 1'b0;
        st    = 4'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic sweep(input logic addr_mode, input logic m);
        logic [31:0] a;
        logic [3:0]  e;
        mem = m;
        for (int w = 0; w < 8; w++) begin
            for (int k = 0; k < 4; k++) begin
                case (k)
                    0:       a = W_LO[w] - 32'd1;
                    1:       a = W_LO[w];
                    2:       a = W_HI[w];
                    default: a = W_HI[w] + 32'd1;
                endcase
                step(1'b1, 4'd1, a);
                if (addr_mode) begin
                    chk("R2 boundary sweep", pins, a[31:28]);
                end else begin
                    e = model_sel(a, m);
                    chk(m ? "R3/R4 boundary sweep" : "R5 io sweep", pins, e);
                    chk("R9 at most one low", 4'($countones(~pins) <= 1), 4'd1);
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // ---- select mode ----
        @(negedge clk);
        do_reset(1'b0);
        chk("R10 reset value", pins, 4'hF);
        b16 = 1'b0;
        sweep(1'b0, 1'b1);
        sweep(1'b0, 1'b0);

        // R1: strap change after reset ignored
        mem = 1'b1;
        strap = 1'b1;
        step(1'b1, 4'd1, 32'h0000_2000);
        chk("R1 strap ignored after reset", pins, 4'b1101);

        // R4: low 4 KB and gaps
        step(1'b1, 4'd1, 32'h0000_0FFF);
        chk("R4 low page no select", pins, 4'hF);
        step(1'b1, 4'd1, 32'h3000_0000);
        chk("R4 gap no select", pins, 4'hF);
        step(1'b1, 4'd1, 32'h8000_0000);
        chk("R4 upper gap no select", pins, 4'hF);

        // R6: idle deselect
        step(1'b1, 4'd1, 32'h4000_0000);
        chk("R3 cs1 uncachable", pins, 4'b1101);
        step(1'b0, 4'd0, 32'h4000_0000);
        chk("R6 idle deselect", pins, 4'hF);

        // R7: 32-bit update states
        step(1'b1, 4'd1, 32'h1000_0000);
        chk("R7 addr state update", pins, 4'b1011);
        step(1'b1, 4'd2, 32'h2000_0000);
        chk("R7 setup holds", pins, 4'b1011);
        step(1'b1, 4'd3, 32'h2000_0000);
        chk("R7 wait1 holds", pins, 4'b1011);
        step(1'b1, 4'd4, 32'h2000_0000);
        chk("R7 wait2 holds in 32-bit", pins, 4'b1011);
        step(1'b1, 4'd5, 32'h2000_0000);
        chk("R7 beat1 holds", pins, 4'b1011);
        step(1'b1, 4'd6, 32'h2000_0000);
        chk("R7 beat2 updates", pins, 4'b0111);
        step(1'b1, 4'd8, 32'h7E00_0000);
        chk("R7 beat4 updates", pins, 4'b1110);
        step(1'b1, 4'd9, 32'h5000_0000);
        chk("R7 beat5 holds in 32-bit", pins, 4'b1110);
        step(1'b1, 4'd12, 32'h5000_0000);
        chk("R7 beat8 holds in 32-bit", pins, 4'b1110);

        // R8: 16-bit update states
        b16 = 1'b1;
        step(1'b1, 4'd1, 32'h5000_0000);
        chk("R8 addr state update", pins, 4'b1011);
        step(1'b1, 4'd3, 32'h6000_0000);
        chk("R8 wait1 holds", pins, 4'b1011);
        step(1'b1, 4'd4, 32'h6000_0000);
        chk("R8 wait2 updates", pins, 4'b0111);
        step(1'b1, 4'd5, 32'h4000_0000);
        chk("R8 beat1 holds", pins, 4'b0111);
        step(1'b1, 4'd12, 32'h4000_0000);
        chk("R8 beat8 updates", pins, 4'b1101);
        step(1'b1, 4'd10, 32'hFE00_1000);
        chk("R8 beat6 updates", pins, 4'b1110);
        b16 = 1'b0;
        step(1'b0, 4'd0, 32'h0);

        // ---- address mode ----
        do_reset(1'b1);
        chk("R10 reset value addr mode", pins, 4'hF);
        sweep(1'b1, 1'b1);
        sweep(1'b1, 1'b0);
        strap = 1'b0;
        step(1'b1, 4'd1, 32'hA000_0000);
        chk("R1 strap ignored addr mode", pins, 4'hA);
        step(1'b1, 4'd2, 32'h3000_0000);
        chk("R2 setup holds address", pins, 4'hA);
        step(1'b0, 4'd0, 32'h3000_0000);
        chk("R2 idle holds address", pins, 4'hA);
        step(1'b1, 4'd7, 32'hC000_0000);
        chk("R2 beat3 updates address", pins, 4'hC);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule